// File: doc/BRIEF.md
# Pseudo-SRAM Bus Operation Decoder

This block sits on the device side of a 16-bit pseudo-static RAM interface. It registers the external control pins once per internal clock. It then classifies the sampled access as one of eleven bus operations: standby, no-operation, asynchronous read or write, configuration read or write, initial burst read or write, burst continue, burst suspend, or deep power-down. From that classification it produces the per-byte lane enables, the per-byte DQ output enables, the read data to put on DQ, and a WAIT output whose active level is set by software.

Two 16-bit configuration registers live inside the block. Bit 15 of the bus register chooses between asynchronous-only decoding and burst decoding, and bit 10 of the same register sets the WAIT polarity. Bit 4 of the refresh register arms deep power-down. Once deep power-down is armed, a rising chip-enable enters it and a later falling chip-enable leaves it. While the device is in deep power-down every access is ignored and both registers keep their values. A configuration write takes its data and its register select from the address-side inputs. Array data and the array's busy flag enter on their own inputs.

Top module: `psram_bus_decoder`

## Requirements
- R1: After reset the bus register reads 0x8400 (asynchronous mode, WAIT active high) and the refresh register reads 0x0010 (power-down not armed). The op code output is one-hot with bit 0 standby, 1 no-op, 2 async read, 3 async write, 4 config read, 5 config write, 6 initial burst read, 7 initial burst write, 8 burst continue, 9 burst suspend, 10 deep power-down.
- R2: With chip-enable low, CRE low and ADV# low in asynchronous mode (bus bit 15 = 1), WE# high with OE# low is an async read and WE# low with OE# high is an async write. Any other OE#/WE# pair, and any ADV# high cycle, is a no-op with DQ not driven.
- R3: With chip-enable low, CRE high and ADV# low, WE# low with OE# high is a config write. It loads the data input into the bus register (select 0) or the refresh register (select 1) from the next cycle on, and DQ is not driven. WE# high with OE# low is a config read, which drives the selected register on DQ with both byte enables set.
- R4: In burst mode (bus bit 15 = 0) with CRE low and ADV# low, WE# high is an initial burst read. WE# low with OE# high is an initial burst write when the sampled bus clock is high, and an async write when it is low.
- R5: In burst mode with ADV# high and chip-enable low, an open read burst gives burst continue (array data driven) when OE# is low and burst suspend (DQ released) when OE# is high. An open write burst gives burst continue with nothing driven. With no open burst the cycle is a no-op. Chip-enable high, or any non-burst access, closes the burst.
- R6: For async read, async write and burst continue, lane_en bit 1 (DQ[15:8]) is the inverse of UB# and bit 0 (DQ[7:0]) is the inverse of LB#. A read drives DQ on exactly those lanes. Every other operation has both lane enables at 0.
- R7: Chip-enable high is standby: DQ and WAIT are not driven, lane enables are 0 and no register changes.
- R8: WAIT is driven while chip-enable is low outside deep power-down. It is asserted during an initial burst read, an initial burst write, and a burst continue while the array reports busy. When it is asserted its level is bus bit 10, and otherwise its level is the inverse of that bit. When WAIT is not driven the output is 0.
- R9: With refresh bit 4 at 0, a sampled rising chip-enable enters deep power-down from the following cycle. While the device is in deep power-down the op code is deep power-down, nothing is driven, and a config write has no effect.
- R10: A sampled falling chip-enable ends deep power-down. That cycle is still ignored, and the next cycle decodes normally in the mode held in the bus register.
- R11: The outputs follow the pins sampled at the previous internal clock edge, so there is one cycle of latency from pin to output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_clk | input | 1 | Sampled level of the external bus clock |
| adv_n | input | 1 | Address valid, active low |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| cre | input | 1 | Configuration register access enable |
| ub_n | input | 1 | Upper byte select, active low |
| lb_n | input | 1 | Lower byte select, active low |
| cfg_sel | input | 1 | Register select for config access (0 bus, 1 refresh) |
| cfg_wdata | input | 16 | Config write value from the address side |
| arr_rdata | input | 16 | Read data from the memory array |
| arr_wait | input | 1 | Array busy during burst continue |
| op_code | output | 11 | One-hot decoded operation |
| lane_en | output | 2 | Byte lane enables (bit 1 upper) |
| dq_out | output | 16 | Data to drive on DQ |
| dq_oe | output | 2 | Per-byte DQ output enable |
| wait_out | output | 1 | WAIT level |
| wait_oe | output | 1 | WAIT output enable |
| dpd_active | output | 1 | Deep power-down state |

## Verification
The assertions check on every cycle that standby, config writes, burst suspend and deep power-down never drive DQ. They also check that lane enables always match the sampled byte selects, that WAIT during an initial burst read takes the level of the polarity bit, that deep power-down freezes both registers and ends after a sampled falling chip-enable, and that a high chip-enable closes any burst. The following can be shown only by the bench's scenarios, where a cycle-level model checks every output: the full decode table in both modes, the sync/async split of burst-mode writes, the choice between suspend and continue by burst direction, register write-then-read, and the arm, enter, ignore and exit sequence of deep power-down.

// File: rtl/psram_pkg.sv
package psram_pkg;

    localparam int DW        = 16;
    localparam int OP_N      = 11;
    localparam int OP_W      = $clog2(OP_N);
    localparam int MODE_BIT  = 15;
    localparam int WPOL_BIT  = 10;
    localparam int ARM_BIT   = 4;

    typedef logic [OP_W-1:0] op_idx_t;

    localparam op_idx_t OP_STBY  = op_idx_t'(0);
    localparam op_idx_t OP_NOP   = op_idx_t'(1);
    localparam op_idx_t OP_ARD   = op_idx_t'(2);
    localparam op_idx_t OP_AWR   = op_idx_t'(3);
    localparam op_idx_t OP_CRD   = op_idx_t'(4);
    localparam op_idx_t OP_CWR   = op_idx_t'(5);
    localparam op_idx_t OP_BRD   = op_idx_t'(6);
    localparam op_idx_t OP_BWR   = op_idx_t'(7);
    localparam op_idx_t OP_BCONT = op_idx_t'(8);
    localparam op_idx_t OP_BSUSP = op_idx_t'(9);
    localparam op_idx_t OP_DPD   = op_idx_t'(10);

    typedef enum logic [1:0] {
        BD_NONE  = 2'd0,
        BD_READ  = 2'd1,
        BD_WRITE = 2'd2
    } bdir_e;

    typedef struct packed {
        logic          bus_clk;
        logic          adv_n;
        logic          ce_n;
        logic          oe_n;
        logic          we_n;
        logic          cre;
        logic          ub_n;
        logic          lb_n;
        logic          cfg_sel;
        logic [DW-1:0] wdata;
    } pins_t;

    localparam pins_t PINS_IDLE = '{bus_clk: 1'b0, adv_n: 1'b1, ce_n: 1'b1,
                                    oe_n: 1'b1, we_n: 1'b1, cre: 1'b0,
                                    ub_n: 1'b1, lb_n: 1'b1, cfg_sel: 1'b0,
                                    wdata: '0};

    function automatic logic [1:0] lanes_of(input logic ub_n, input logic lb_n);
        return {~ub_n, ~lb_n};
    endfunction

endpackage

// File: rtl/psram_pin_sampler.sv
module psram_pin_sampler
    import psram_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  pins_t pins_d,
    output pins_t pins_q
);

    always_ff @(posedge clk) begin
        if (rst) pins_q <= PINS_IDLE;
        else     pins_q <= pins_d;
    end

endmodule

// File: rtl/psram_op_decode.sv
module psram_op_decode
    import psram_pkg::*;
(
    input  logic            bus_clk,
    input  logic            adv_n,
    input  logic            ce_n,
    input  logic            oe_n,
    input  logic            we_n,
    input  logic            cre,
    input  logic            async_mode,
    input  logic            dpd,
    input  bdir_e           bdir,
    output op_idx_t         op_idx,
    output logic [OP_N-1:0] op_oh
);

    logic rd_pair, wr_pair;

    assign rd_pair = we_n && !oe_n;
    assign wr_pair = !we_n && oe_n;

    always_comb begin
        op_idx = OP_NOP;
        if (dpd) begin
            op_idx = OP_DPD;
        end else if (ce_n) begin
            op_idx = OP_STBY;
        end else if (!adv_n) begin
            if (cre) begin
                if (wr_pair)      op_idx = OP_CWR;
                else if (rd_pair) op_idx = OP_CRD;
            end else if (async_mode) begin
                if (rd_pair)      op_idx = OP_ARD;
                else if (wr_pair) op_idx = OP_AWR;
            end else begin
                if (we_n)         op_idx = OP_BRD;
                else if (oe_n)    op_idx = bus_clk ? OP_BWR : OP_AWR;
            end
        end else if (!async_mode && !cre) begin
            unique case (bdir)
                BD_READ:  op_idx = oe_n ? OP_BSUSP : OP_BCONT;
                BD_WRITE: op_idx = OP_BCONT;
                default:  op_idx = OP_NOP;
            endcase
        end
    end

    for (genvar i = 0; i < OP_N; i++) begin : g_onehot
        assign op_oh[i] = (op_idx == op_idx_t'(i));
    end

endmodule

// File: rtl/psram_cfg_regs.sv
module psram_cfg_regs
    import psram_pkg::*;
#(
    parameter logic [DW-1:0] BUS_RST = 16'h8400,
    parameter logic [DW-1:0] REF_RST = 16'h0010
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic          sel,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] bus_reg,
    output logic [DW-1:0] ref_reg,
    output logic [DW-1:0] rd_data
);

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_reg <= BUS_RST;
            ref_reg <= REF_RST;
        end else if (wr_en) begin
            if (sel) ref_reg <= wdata;
            else     bus_reg <= wdata;
        end
    end

    assign rd_data = sel ? ref_reg : bus_reg;

endmodule

// File: rtl/psram_state_track.sv
module psram_state_track
    import psram_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    ce_n_q,
    input  logic    arm_n,
    input  op_idx_t op_idx,
    output logic    dpd,
    output bdir_e   bdir
);

    logic ce_prev;
    logic ce_rise, ce_fall;

    assign ce_rise = ce_n_q && !ce_prev;
    assign ce_fall = !ce_n_q && ce_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            ce_prev <= 1'b1;
            dpd     <= 1'b0;
            bdir    <= BD_NONE;
        end else begin
            ce_prev <= ce_n_q;
            if (!dpd && ce_rise && !arm_n) dpd <= 1'b1;
            else if (dpd && ce_fall)        dpd <= 1'b0;
            if (dpd || ce_n_q) begin
                bdir <= BD_NONE;
            end else begin
                unique case (op_idx)
                    OP_BRD:                         bdir <= BD_READ;
                    OP_BWR:                         bdir <= BD_WRITE;
                    OP_ARD, OP_AWR, OP_CRD, OP_CWR: bdir <= BD_NONE;
                    default:                        bdir <= bdir;
                endcase
            end
        end
    end

    AST_CE_HIGH_CLOSES_BURST: assert property (@(posedge clk) disable iff (rst)
        ce_n_q |=> bdir == BD_NONE) else $error("burst left open after CE high"); // R5

endmodule

// File: rtl/psram_dq_drive.sv
module psram_dq_drive
    import psram_pkg::*;
(
    input  logic          op_ard,
    input  logic          op_awr,
    input  logic          op_crd,
    input  logic          op_brd,
    input  logic          op_bwr,
    input  logic          op_bcont,
    input  bdir_e         bdir,
    input  logic          ce_n_q,
    input  logic          dpd,
    input  logic          ub_n,
    input  logic          lb_n,
    input  logic          wait_pol,
    input  logic          arr_wait,
    input  logic [DW-1:0] arr_rdata,
    input  logic [DW-1:0] cfg_rdata,
    output logic [1:0]    lane_en,
    output logic [1:0]    dq_oe,
    output logic [DW-1:0] dq_out,
    output logic          wait_out,
    output logic          wait_oe
);

    logic       moves_data, array_read, busy;
    logic [1:0] lanes;

    assign lanes      = lanes_of(ub_n, lb_n);
    assign moves_data = op_ard || op_awr || op_bcont;
    assign array_read = op_ard || (op_bcont && bdir == BD_READ);
    assign busy       = op_brd || op_bwr || (op_bcont && arr_wait);

    always_comb begin
        lane_en = moves_data ? lanes : 2'b00;
        if (op_crd) begin
            dq_oe  = 2'b11;
            dq_out = cfg_rdata;
        end else if (array_read) begin
            dq_oe  = lanes;
            dq_out = arr_rdata;
        end else begin
            dq_oe  = 2'b00;
            dq_out = '0;
        end
        wait_oe  = !ce_n_q && !dpd;
        wait_out = wait_oe && (busy ? wait_pol : !wait_pol);
    end

endmodule

// File: rtl/psram_bus_decoder.sv
module psram_bus_decoder
    import psram_pkg::*;
#(
    parameter logic [15:0] BUS_RST = 16'h8400,
    parameter logic [15:0] REF_RST = 16'h0010
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            bus_clk,
    input  logic            adv_n,
    input  logic            ce_n,
    input  logic            oe_n,
    input  logic            we_n,
    input  logic            cre,
    input  logic            ub_n,
    input  logic            lb_n,
    input  logic            cfg_sel,
    input  logic [15:0]     cfg_wdata,
    input  logic [15:0]     arr_rdata,
    input  logic            arr_wait,
    output logic [10:0]     op_code,
    output logic [1:0]      lane_en,
    output logic [15:0]     dq_out,
    output logic [1:0]      dq_oe,
    output logic            wait_out,
    output logic            wait_oe,
    output logic            dpd_active
);

    pins_t           pd, pq;
    op_idx_t         op_idx;
    logic [OP_N-1:0] op_oh;
    logic [DW-1:0]   bus_reg, ref_reg, cfg_rdata;
    logic            dpd;
    bdir_e           bdir;

    assign pd = '{bus_clk: bus_clk, adv_n: adv_n, ce_n: ce_n, oe_n: oe_n,
                  we_n: we_n, cre: cre, ub_n: ub_n, lb_n: lb_n,
                  cfg_sel: cfg_sel, wdata: cfg_wdata};

    psram_pin_sampler u_smp (
        .clk    (clk),
        .rst    (rst),
        .pins_d (pd),
        .pins_q (pq)
    );

    psram_op_decode u_dec (
        .bus_clk    (pq.bus_clk),
        .adv_n      (pq.adv_n),
        .ce_n       (pq.ce_n),
        .oe_n       (pq.oe_n),
        .we_n       (pq.we_n),
        .cre        (pq.cre),
        .async_mode (bus_reg[MODE_BIT]),
        .dpd        (dpd),
        .bdir       (bdir),
        .op_idx     (op_idx),
        .op_oh      (op_oh)
    );

    psram_cfg_regs #(
        .BUS_RST (BUS_RST),
        .REF_RST (REF_RST)
    ) u_cfg (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (op_oh[OP_CWR]),
        .sel     (pq.cfg_sel),
        .wdata   (pq.wdata),
        .bus_reg (bus_reg),
        .ref_reg (ref_reg),
        .rd_data (cfg_rdata)
    );

    psram_state_track u_st (
        .clk    (clk),
        .rst    (rst),
        .ce_n_q (pq.ce_n),
        .arm_n  (ref_reg[ARM_BIT]),
        .op_idx (op_idx),
        .dpd    (dpd),
        .bdir   (bdir)
    );

    psram_dq_drive u_drv (
        .op_ard    (op_oh[OP_ARD]),
        .op_awr    (op_oh[OP_AWR]),
        .op_crd    (op_oh[OP_CRD]),
        .op_brd    (op_oh[OP_BRD]),
        .op_bwr    (op_oh[OP_BWR]),
        .op_bcont  (op_oh[OP_BCONT]),
        .bdir      (bdir),
        .ce_n_q    (pq.ce_n),
        .dpd       (dpd),
        .ub_n      (pq.ub_n),
        .lb_n      (pq.lb_n),
        .wait_pol  (bus_reg[WPOL_BIT]),
        .arr_wait  (arr_wait),
        .arr_rdata (arr_rdata),
        .cfg_rdata (cfg_rdata),
        .lane_en   (lane_en),
        .dq_oe     (dq_oe),
        .dq_out    (dq_out),
        .wait_out  (wait_out),
        .wait_oe   (wait_oe)
    );

    assign op_code    = op_oh;
    assign dpd_active = dpd;

    AST_STANDBY_QUIET: assert property (@(posedge clk) disable iff (rst)
        (!dpd_active && pq.ce_n) |-> (dq_oe == 2'b00 && lane_en == 2'b00 && !wait_oe))
        else $error("standby drives outputs"); // R7
    AST_CWR_NO_DRIVE: assert property (@(posedge clk) disable iff (rst)
        op_code[OP_CWR] |-> dq_oe == 2'b00) else $error("config write drives DQ"); // R3
    AST_SUSPEND_RELEASE: assert property (@(posedge clk) disable iff (rst)
        op_code[OP_BSUSP] |-> dq_oe == 2'b00) else $error("suspend drives DQ"); // R5
    AST_LANE_MATCH: assert property (@(posedge clk) disable iff (rst)
        (lane_en != 2'b00) |-> lane_en == {~pq.ub_n, ~pq.lb_n}) else $error("lane mismatch"); // R6
    AST_WAIT_POLARITY: assert property (@(posedge clk) disable iff (rst)
        (wait_oe && op_code[OP_BRD]) |-> wait_out == bus_reg[WPOL_BIT])
        else $error("WAIT polarity wrong"); // R8
    AST_DPD_QUIET: assert property (@(posedge clk) disable iff (rst)
        dpd_active |-> (!wait_oe && dq_oe == 2'b00 && op_code[OP_DPD]))
        else $error("DPD not quiet"); // R9
    AST_DPD_FREEZE: assert property (@(posedge clk) disable iff (rst)
        dpd_active |=> ($stable(bus_reg) && $stable(ref_reg)))
        else $error("register changed in DPD"); // R9
    AST_DPD_EXIT: assert property (@(posedge clk) disable iff (rst)
        (dpd_active && !pq.ce_n && $past(pq.ce_n)) |=> !dpd_active)
        else $error("DPD not left on CE fall"); // R10

endmodule

// File: tb/sim_psram_bus_decoder.sv
module sim_psram_bus_decoder;
    import psram_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;

    pins_t       drv = PINS_IDLE;
    logic [15:0] arr_rdata = 16'h0;
    logic        arr_wait = 1'b0;
    logic [10:0] op_code;
    logic [1:0]  lane_en, dq_oe;
    logic [15:0] dq_out;
    logic        wait_out, wait_oe, dpd_active;

    int checks = 0;
    int errors = 0;

    psram_bus_decoder u0 (
        .clk(clk), .rst(rst), .bus_clk(drv.bus_clk), .adv_n(drv.adv_n),
        .ce_n(drv.ce_n), .oe_n(drv.oe_n), .we_n(drv.we_n), .cre(drv.cre),
        .ub_n(drv.ub_n), .lb_n(drv.lb_n), .cfg_sel(drv.cfg_sel),
        .cfg_wdata(drv.wdata), .arr_rdata(arr_rdata), .arr_wait(arr_wait),
        .op_code(op_code), .lane_en(lane_en), .dq_out(dq_out), .dq_oe(dq_oe),
        .wait_out(wait_out), .wait_oe(wait_oe), .dpd_active(dpd_active)
    );

    // reference model state
    pins_t       m_q;
    logic [15:0] m_bus, m_ref;
    logic        m_dpd, m_ceprev;
    int          m_bd; // 0 none, 1 read, 2 write

    function automatic int ref_op(pins_t q, logic [15:0] b, logic d, int bd);
        logic rd, wr;
        rd = q.we_n && !q.oe_n;
        wr = !q.we_n && q.oe_n;
        if (d) return 10;
        if (q.ce_n) return 0;
        if (!q.adv_n) begin
            if (q.cre) return wr ? 5 : (rd ? 4 : 1);
            if (b[15]) return rd ? 2 : (wr ? 3 : 1);
            if (q.we_n) return 6;
            if (q.oe_n) return q.bus_clk ? 7 : 3;
            return 1;
        end
        if (b[15] || q.cre) return 1;
        if (bd == 1) return q.oe_n ? 9 : 8;
        if (bd == 2) return 8;
        return 1;
    endfunction

    function automatic string tag_of(int op);
        case (op)
            0: return "R7";
            1, 2, 3: return "R2";
            4, 5: return "R3";
            6, 7: return "R4";
            8, 9: return "R5";
            default: return "R9";
        endcase
    endfunction

    task automatic model_reset();
        m_q = PINS_IDLE; m_bus = 16'h8400; m_ref = 16'h0010;
        m_dpd = 1'b0; m_ceprev = 1'b1; m_bd = 0;
    endtask

    task automatic model_edge();
        int op;
        op = ref_op(m_q, m_bus, m_dpd, m_bd);
        if (op == 5) begin
            if (m_q.cfg_sel) m_ref = m_q.wdata; else m_bus = m_q.wdata;
        end
        if (m_dpd || m_q.ce_n) m_bd = 0;
        else if (op == 6) m_bd = 1;
        else if (op == 7) m_bd = 2;
        else if (op >= 2 && op <= 5) m_bd = 0;
        if (!m_dpd && m_q.ce_n && !m_ceprev && !m_ref[4]) m_dpd = 1'b1;
        else if (m_dpd && !m_q.ce_n && m_ceprev) m_dpd = 1'b0;
        m_ceprev = m_q.ce_n;
        m_q = drv;
    endtask

    task automatic compare(input string tag);
        int          op;
        logic [1:0]  lanes, e_lane, e_oe;
        logic [15:0] e_dq;
        logic        busy, e_woe, e_w;
        op    = ref_op(m_q, m_bus, m_dpd, m_bd);
        lanes = {~m_q.ub_n, ~m_q.lb_n};
        e_lane = (op == 2 || op == 3 || op == 8) ? lanes : 2'b00;
        if (op == 4) begin e_oe = 2'b11; e_dq = m_q.cfg_sel ? m_ref : m_bus; end
        else if (op == 2 || (op == 8 && m_bd == 1)) begin e_oe = lanes; e_dq = arr_rdata; end
        else begin e_oe = 2'b00; e_dq = 16'h0; end
        busy  = (op == 6) || (op == 7) || (op == 8 && arr_wait);
        e_woe = !m_q.ce_n && !m_dpd;
        e_w   = e_woe && (busy ? m_bus[10] : !m_bus[10]);
        checks++;
        if (op_code !== (11'd1 << op) || lane_en !== e_lane || dq_oe !== e_oe ||
            dq_out !== e_dq || wait_oe !== e_woe || wait_out !== e_w || dpd_active !== m_dpd) begin
            errors++;
            $display("FAIL %s: op=%b lane=%b oe=%b dq=%h woe=%b w=%b dpd=%b exp op=%b lane=%b oe=%b dq=%h woe=%b w=%b dpd=%b",
                     tag, op_code, lane_en, dq_oe, dq_out, wait_oe, wait_out, dpd_active,
                     11'd1 << op, e_lane, e_oe, e_dq, e_woe, e_w, m_dpd);
        end
    endtask

    task automatic check_val(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic pins_t mk(logic ce, logic adv, logic cr, logic we, logic oe,
                                 logic ub, logic lb, logic bc, logic sel, logic [15:0] d);
        pins_t p;
        p = '{bus_clk: bc, adv_n: adv, ce_n: ce, oe_n: oe, we_n: we, cre: cr,
              ub_n: ub, lb_n: lb, cfg_sel: sel, wdata: d};
        return p;
    endfunction

    task automatic step(input pins_t p, input string tag);
        drv = p;
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare(tag);
    endtask

    initial begin
        #(20 * 200000);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        compare("R1");                       // reset state: standby
        arr_rdata = 16'hA55A;
        // R1: register reset values through config read
        step(mk(0,0,1,1,0,1,1,0,0,16'h0), "R1");
        check_val("R1", dq_out, 16'h8400);
        step(mk(0,0,1,1,0,1,1,0,1,16'h0), "R1");
        check_val("R1", dq_out, 16'h0010);
        // R2 async decode, R6 lanes
        step(mk(0,0,0,1,0,0,0,0,0,16'h0), "R2");
        step(mk(0,0,0,1,0,1,0,0,0,16'h0), "R6");
        check_val("R6", {14'h0, dq_oe}, 16'h0001);
        step(mk(0,0,0,0,1,0,1,0,0,16'h0), "R6");
        check_val("R6", {14'h0, lane_en}, 16'h0002);
        step(mk(0,0,0,0,0,0,0,0,0,16'h0), "R2");
        step(mk(0,1,0,1,0,0,0,0,0,16'h0), "R2");
        // R3 config write then read back; R11 one-cycle latency
        step(mk(0,0,1,0,1,0,0,0,1,16'h0013), "R3");
        step(mk(0,0,1,1,0,0,0,0,1,16'h0), "R11");
        check_val("R3", dq_out, 16'h0013);
        // switch to burst mode, WAIT active low
        step(mk(0,0,1,0,1,0,0,0,0,16'h0000), "R3");
        step(mk(0,0,0,1,0,0,0,1,0,16'h0), "R4");
        check_val("R8", {15'h0, wait_out}, 16'h0000);
        arr_wait = 1'b0;
        step(mk(0,1,0,1,0,0,0,1,0,16'h0), "R5");
        check_val("R8", {15'h0, wait_out}, 16'h0001);
        arr_wait = 1'b1;
        step(mk(0,1,0,1,0,0,1,1,0,16'h0), "R8");
        arr_wait = 1'b0;
        step(mk(0,1,0,1,1,0,0,1,0,16'h0), "R5");
        step(mk(1,1,0,1,1,1,1,0,0,16'h0), "R7");
        step(mk(0,1,0,1,0,0,0,1,0,16'h0), "R5");   // no open burst -> nop
        step(mk(0,0,0,0,1,0,0,1,0,16'h0), "R4");   // sync write
        step(mk(0,1,0,0,1,0,0,1,0,16'h0), "R5");
        step(mk(0,0,0,0,1,0,0,0,0,16'h0), "R4");   // async write in burst mode
        // R9 arm and enter deep power-down
        step(mk(0,0,1,0,1,0,0,0,1,16'h0000), "R9");
        step(mk(1,1,0,1,1,1,1,0,0,16'h0), "R9");
        step(mk(1,1,0,1,1,1,1,0,0,16'h0), "R9");
        check_val("R9", {15'h0, dpd_active}, 16'h0001);
        step(mk(1,0,1,0,1,0,0,0,0,16'h8400), "R9");
        step(mk(0,0,1,0,1,0,0,0,0,16'h8400), "R10");  // exit cycle ignored
        step(mk(0,0,1,1,0,0,0,0,0,16'h0), "R10");
        check_val("R10", dq_out, 16'h0000);
        step(mk(0,0,0,1,0,0,0,1,0,16'h0), "R10");      // burst mode retained
        // random phase
        for (int i = 0; i < 3000; i++) begin
            logic [31:0] r;
            pins_t p;
            r = $urandom;
            p = mk(r[3:0] == 0, r[4], r[7:5] == 0, r[8], r[9], r[10], r[11],
                   r[12], r[13], $urandom);
            arr_rdata = $urandom;
            arr_wait  = r[14];
            drv = p;
            @(posedge clk);
            model_edge();
            @(negedge clk);
            compare(tag_of(ref_op(m_q, m_bus, m_dpd, m_bd)));
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule